// File: doc/BRIEF.md
# Programmable-Modulus Third-Order Sigma-Delta Modulator

This block generates the per-reference-cycle integer offset that a fractional-N feedback divider adds to its integer ratio. It takes a fractional numerator and a programmable modulus. It emits a short signed sequence whose long-run mean is exactly numerator/modulus. The block advances once for each phase-detector reference cycle, signalled by a tick strobe.

The core is three cascaded accumulators. Each stage wraps at the programmed modulus, not at a power of two. The three carries are recombined by a first-, second- and third-order difference network, which cancels the quantisation error of the earlier stages.

In the quiet mode the output is strictly periodic, and the period depends on how the modulus factors. In the spread mode a 21-bit maximal-length shift register feeds a pseudo-random bit into the last stage, which breaks up that periodicity. The mean is not disturbed, because the last stage's carry reaches the output only through a second difference.

Configuration is loaded through a write strobe. Every write restarts the sequence from a cleared state. Settings that cannot be honoured are flagged.

Top module: `mash_frac_sdm`

## Requirements
- R1: After reset, `offset_out` is 0, `cfg_bad` and `dither_blocked` are 0, and the loaded setting is numerator 0 with modulus 2.
- R2: Each accumulator keeps a value below the modulus. A stage adds its input to its held value and emits carry 1, subtracting the modulus, when the sum is greater than or equal to the modulus. Stage 1 adds the numerator, stage 2 adds stage 1's wrapped sum of the same step, and stage 3 adds stage 2's wrapped sum plus the dither bit. With dither off the output after step n is c1 + c2 − c2[n−1] + c3 − 2·c3[n−1] + c3[n−2], with all history cleared to 0 at restart.
- R3: `offset_out` is a 4-bit two's-complement value that always lies in −3..+4.
- R4: Over any N steps counted from a restart, the output sum S satisfies |S·MOD − N·FRAC| ≤ 3·MOD, with dither either on or off.
- R5: With dither off and FRAC coprime to MOD, the output repeats with period 6·MOD if 6 divides MOD, 2·MOD if MOD is even but not divisible by 3, 3·MOD if MOD is odd and divisible by 3, and MOD otherwise.
- R6: With dither on, the dither bit is bit 0 of a 21-bit shift register. The register is set to 1 at restart, shifts left once per step, and takes as its new bit 0 the XOR of bits 20 and 18. The bit is added into stage 3's sum.
- R7: A dither request with MOD < 50 sets `dither_blocked`, and the output then follows the dither-off sequence. With MOD ≥ 50 the request is honoured.
- R8: MOD < 2 or FRAC ≥ MOD sets `cfg_bad`. The accumulators then stay frozen and `offset_out` stays 0.
- R9: With FRAC = 0, `offset_out` is 0 on every step, even with dither on.
- R10: A `cfg_wr` pulse loads the new setting and clears all accumulators, history, shift-register state and the output, so identical settings reproduce an identical sequence.
- R11: A cycle with `ref_tick` low neither advances the state nor changes `offset_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per reference cycle; advances the modulator |
| cfg_wr | input | 1 | Loads the three settings below and restarts the sequence |
| frac_in | input | 12 | Fractional numerator |
| mod_in | input | 12 | Modulus |
| dither_req | input | 1 | Requests spread (dithered) mode |
| offset_out | output | 4 | Signed divider offset for the current reference cycle |
| dither_blocked | output | 1 | Dither requested but refused because the modulus is too small |
| cfg_bad | output | 1 | Loaded numerator/modulus pair is unusable |

## Verification
The bench builds the block with its default parameters: a 12-bit modulus field, a 21-bit dither register and a dither floor of 50. This allows moduli up to 4095, so a full 3·MOD period at MOD 4095 can be observed, as well as the 49/50 boundary of the dither floor. Random settings with dither both on and off are compared step by step against a bench model. Directed runs cover the four period classes, invalid pairs, a zero numerator, pausing of the tick and restart reproducibility.

// File: rtl/mash_pkg.sv
// Shared definitions for the programmable-modulus sigma-delta modulator.
// Assumes a third-order cancellation network; ORDER is fixed by that network.
package mash_pkg;
    localparam int ORDER = 3;
    localparam int OUT_W = 4;
    typedef logic signed [OUT_W-1:0] sdm_out_t;
endpackage

// File: rtl/mash_cfg.sv
// Configuration holder: captures numerator, modulus and dither request on a
// write strobe and derives the validity and dither-permission flags.
// Assumes the write strobe is a single-cycle pulse from the owning logic.
module mash_cfg #(
    parameter int MOD_W          = 12,
    parameter int MIN_DITHER_MOD = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [MOD_W-1:0] frac_in,
    input  logic [MOD_W-1:0] mod_in,
    input  logic             dither_req,
    output logic [MOD_W-1:0] frac_q,
    output logic [MOD_W-1:0] mod_q,
    output logic             dither_on,
    output logic             dither_blocked,
    output logic             cfg_bad,
    output logic             frac_zero
);
    localparam logic [MOD_W-1:0] MIN_MOD_DITH = MOD_W'(MIN_DITHER_MOD);
    localparam logic [MOD_W-1:0] MIN_MOD      = MOD_W'(2);

    logic req_q;

    // Capture the settings on a write; reset gives numerator 0, modulus 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frac_q <= '0;
            mod_q  <= MIN_MOD;
            req_q  <= 1'b0;
        end else if (cfg_wr) begin
            frac_q <= frac_in;
            mod_q  <= mod_in;
            req_q  <= dither_req;
        end
    end

    // Derive validity and dither permission from the held settings.
    always_comb begin
        cfg_bad        = (mod_q < MIN_MOD) || (frac_q >= mod_q);
        dither_blocked = req_q && (mod_q < MIN_MOD_DITH);
        dither_on      = req_q && !dither_blocked;
        frac_zero      = (frac_q == '0);
    end

    // R10: settings change only on a write.
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(frac_q) && $stable(mod_q)));
endmodule

// File: rtl/mash_stage.sv
// One modulo-MOD accumulator stage: adds its input (plus an optional
// injected bit) to the held value, wraps at the modulus and raises carry.
// Assumes addend < mod_q and held value < mod_q, so one subtraction suffices.
module mash_stage #(
    parameter int MOD_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [MOD_W-1:0] mod_q,
    input  logic [MOD_W-1:0] addend,
    input  logic             inject,
    output logic [MOD_W-1:0] wrapped,
    output logic             carry
);
    localparam int SUM_W = MOD_W + 1;

    logic [MOD_W-1:0] acc_q;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] sum_less;

    // Form the sum, compare against the modulus and wrap.
    always_comb begin
        sum      = {1'b0, acc_q} + {1'b0, addend} + SUM_W'(inject);
        carry    = (sum >= {1'b0, mod_q});
        sum_less = sum - {1'b0, mod_q};
        wrapped  = carry ? sum_less[MOD_W-1:0] : sum[MOD_W-1:0];
    end

    // Hold the accumulator; clear on reset or restart, update on a step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc_q <= '0;
        else if (adv)      acc_q <= wrapped;
    end

    // R2: held value never reaches the modulus.
    assert_acc_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q < mod_q) || (acc_q == '0));
endmodule

// File: rtl/mash_dither.sv
// Pseudo-random dither source: Fibonacci shift register, seeded to 1 at
// restart, stepped once per modulator step. Assumes TAPS describes a
// maximal-length polynomial for width W.
module mash_dither #(
    parameter int         W    = 21,
    parameter logic [W-1:0] TAPS = 21'h140000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic dbit
);
    logic [W-1:0] lfsr_q;
    logic         fb;

    // Feedback is the parity of the tapped bits.
    always_comb fb = ^(lfsr_q & TAPS);

    // Shift left on each step; reseed on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) lfsr_q <= W'(1);
        else if (adv)      lfsr_q <= {lfsr_q[W-2:0], fb};
    end

    assign dbit = lfsr_q[0];

    // R6: register never falls into the all-zero lock-up state.
    assert_lfsr_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
endmodule

// File: rtl/mash_cancel.sv
// Error-cancellation network: combines the three carries with their
// delayed copies into one signed offset and registers it.
// Assumes carry[0..2] come from stages 1..3 of the same step.
module mash_cancel
    import mash_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic             force_zero,
    input  logic [ORDER-1:0] carry,
    output sdm_out_t         y_q
);
    logic     c2_d1, c3_d1, c3_d2;
    logic [OUT_W-1:0] y_raw;

    // Sum of first, second and third difference terms, modulo 2^OUT_W.
    always_comb begin
        y_raw = {3'b0, carry[0]}
              + {3'b0, carry[1]} - {3'b0, c2_d1}
              + {3'b0, carry[2]} - {2'b0, c3_d1, 1'b0} + {3'b0, c3_d2};
    end

    // Update history and output on a step; clear on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            c2_d1 <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
            y_q   <= '0;
        end else if (adv) begin
            c2_d1 <= carry[1];
            c3_d1 <= carry[2];
            c3_d2 <= c3_d1;
            y_q   <= force_zero ? '0 : sdm_out_t'(y_raw);
        end
    end

    // R3: output stays inside -3..+4.
    assert_out_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (y_q >= -4'sd3) && (y_q <= 4'sd4));
    // R10: a restart leaves output and history cleared.
    assert_restart_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (y_q == '0 && !c3_d1 && !c3_d2 && !c2_d1));
    // R11: no step, no output change.
    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(y_q));
endmodule

// File: rtl/mash_frac_sdm.sv
// Top of the third-order programmable-modulus sigma-delta modulator.
// Chains three modulo-MOD stages, injects dither into the last stage and
// recombines carries. Assumes ref_tick pulses once per reference cycle.
module mash_frac_sdm
    import mash_pkg::*;
#(
    parameter int                  MOD_W          = 12,
    parameter int                  DITHER_W       = 21,
    parameter logic [DITHER_W-1:0] DITHER_TAPS    = 21'h140000,
    parameter int                  MIN_DITHER_MOD = 50
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_tick,
    input  logic                    cfg_wr,
    input  logic [MOD_W-1:0]        frac_in,
    input  logic [MOD_W-1:0]        mod_in,
    input  logic                    dither_req,
    output logic signed [OUT_W-1:0] offset_out,
    output logic                    dither_blocked,
    output logic                    cfg_bad
);
    localparam logic [MOD_W-1:0] MIN_MOD_DITH = MOD_W'(MIN_DITHER_MOD);

    logic [MOD_W-1:0] frac_q, mod_q;
    logic             dither_on, frac_zero, adv, lfsr_bit, dith_bit;
    logic [MOD_W-1:0] stage_in   [ORDER];
    logic [MOD_W-1:0] stage_wrap [ORDER];
    logic [ORDER-1:0] stage_carry;
    sdm_out_t         y_q;

    mash_cfg #(.MOD_W(MOD_W), .MIN_DITHER_MOD(MIN_DITHER_MOD)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
        .frac_in(frac_in), .mod_in(mod_in), .dither_req(dither_req),
        .frac_q(frac_q), .mod_q(mod_q), .dither_on(dither_on),
        .dither_blocked(dither_blocked), .cfg_bad(cfg_bad), .frac_zero(frac_zero)
    );

    // A step happens on a tick unless a write or an unusable setting blocks it.
    always_comb adv = ref_tick && !cfg_wr && !cfg_bad;

    mash_dither #(.W(DITHER_W), .TAPS(DITHER_TAPS)) u_dither (
        .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .adv(adv), .dbit(lfsr_bit)
    );

    // Dither reaches the chain only when the mode is permitted.
    always_comb dith_bit = dither_on && lfsr_bit;

    for (genvar k = 0; k < ORDER; k++) begin : g_stage
        logic inj;
        if (k == 0) begin : g_first
            assign stage_in[k] = frac_q;
        end else begin : g_next
            assign stage_in[k] = stage_wrap[k-1];
        end
        if (k == ORDER - 1) begin : g_inj
            assign inj = dith_bit;
        end else begin : g_noinj
            assign inj = 1'b0;
        end
        mash_stage #(.MOD_W(MOD_W)) u_stage (
            .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .adv(adv),
            .mod_q(mod_q), .addend(stage_in[k]), .inject(inj),
            .wrapped(stage_wrap[k]), .carry(stage_carry[k])
        );
    end

    mash_cancel u_cancel (
        .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .adv(adv),
        .force_zero(frac_zero), .carry(stage_carry), .y_q(y_q)
    );

    assign offset_out = y_q;

    // R7: a dither bit never enters the chain below the modulus floor.
    assert_dither_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dith_bit |-> (mod_q >= MIN_MOD_DITH));
    // R8: an unusable setting keeps the output at zero.
    assert_bad_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |=> (offset_out == '0));
    // R9: zero numerator keeps the output at zero.
    assert_frac_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frac_zero |=> (offset_out == '0));
endmodule

// File: tb/tb_mash_frac_sdm.sv
`timescale 1ns/1ps
module tb_mash_frac_sdm;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ref_tick = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [11:0]       frac_in = '0;
    logic [11:0]       mod_in = '0;
    logic              dither_req = 1'b0;
    logic signed [3:0] offset_out;
    logic              dither_blocked, cfg_bad;

    int checks = 0;
    int errors = 0;

    // bench model state
    int m_f, m_m;
    bit m_dith, m_bad;
    int m_a1, m_a2, m_a3;
    int m_c2d, m_c3d, m_c3dd;
    bit [20:0] m_lfsr;

    always #2.5 clk = ~clk;

    mash_frac_sdm dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cfg_wr(cfg_wr),
        .frac_in(frac_in), .mod_in(mod_in), .dither_req(dither_req),
        .offset_out(offset_out), .dither_blocked(dither_blocked), .cfg_bad(cfg_bad)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_restart(input int f, input int m, input bit d);
        m_f = f; m_m = m;
        m_bad  = (m < 2) || (f >= m);
        m_dith = d && (m >= 50);
        m_a1 = 0; m_a2 = 0; m_a3 = 0;
        m_c2d = 0; m_c3d = 0; m_c3dd = 0;
        m_lfsr = 21'd1;
    endtask

    task automatic model_step(output int y);
        int s, c1, c2, c3, db;
        if (m_bad) begin
            y = 0;
            return;
        end
        db = m_dith ? int'(m_lfsr[0]) : 0;
        m_lfsr = {m_lfsr[19:0], m_lfsr[20] ^ m_lfsr[18]};
        s = m_a1 + m_f;  c1 = (s >= m_m); m_a1 = c1 ? s - m_m : s;
        s = m_a2 + m_a1; c2 = (s >= m_m); m_a2 = c2 ? s - m_m : s;
        s = m_a3 + m_a2 + db; c3 = (s >= m_m); m_a3 = c3 ? s - m_m : s;
        y = c1 + c2 - m_c2d + c3 - 2 * m_c3d + m_c3dd;
        m_c2d = c2; m_c3dd = m_c3d; m_c3d = c3;
        if (m_f == 0) y = 0;
    endtask

    task automatic do_cfg(input int f, input int m, input bit d);
        @(negedge clk);
        ref_tick = 1'b0;
        cfg_wr = 1'b1; frac_in = 12'(f); mod_in = 12'(m); dither_req = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        model_restart(f, m, d);
    endtask

    // Step n times, compare with the model, check mean bound; log outputs.
    task automatic run_cmp(input int n, input string req, ref int log_q[$]);
        int e, a, sum;
        longint dev;
        sum = 0;
        ref_tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            model_step(e);
            a = int'(offset_out);
            log_q.push_back(a);
            sum += a;
            chk(a == e, req, a, e);
            chk(a >= -3 && a <= 4, "R3", a, 0);
        end
        ref_tick = 1'b0;
        dev = longint'(sum) * m_m - longint'(n) * m_f;
        if (dev < 0) dev = -dev;
        if (!m_bad) chk(dev <= 3 * m_m, "R4", int'(dev), 3 * m_m);
    endtask

    task automatic period_test(input int f, input int m, input int p);
        int lg[$];
        int bad;
        do_cfg(f, m, 1'b0);
        run_cmp(2 * p, "R2", lg);
        bad = 0;
        for (int i = 0; i < p; i++) if (lg[i] != lg[i + p]) bad++;
        chk(bad == 0, "R5", bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lg[$];
        int lg2[$];
        int diff, hold_v;
        void'($urandom(32'h5D3A7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(offset_out == 0, "R1", int'(offset_out), 0);
        chk(cfg_bad == 0, "R1", cfg_bad, 0);
        chk(dither_blocked == 0, "R1", dither_blocked, 0);

        // R2 / R3 / R4: exact sequences, directed
        do_cfg(1, 2, 1'b0);      run_cmp(40, "R2", lg);
        do_cfg(4094, 4095, 1'b0); run_cmp(200, "R2", lg);
        do_cfg(1, 4095, 1'b0);   run_cmp(200, "R2", lg);

        // R5: period classes
        period_test(3, 10, 20);
        period_test(2, 9, 27);
        period_test(5, 12, 72);
        period_test(3, 7, 7);
        period_test(4094, 4095, 12285);

        // R6: dither on follows the shift-register model and differs from off
        lg.delete(); lg2.delete();
        do_cfg(1, 100, 1'b0); run_cmp(300, "R2", lg);
        do_cfg(1, 100, 1'b1); run_cmp(300, "R6", lg2);
        diff = 0;
        for (int i = 0; i < 300; i++) if (lg[i] != lg2[i]) diff++;
        chk(diff > 0, "R6", diff, 1);

        // R7: dither floor
        do_cfg(5, 49, 1'b1);
        chk(dither_blocked == 1, "R7", dither_blocked, 1);
        run_cmp(150, "R7", lg);
        do_cfg(5, 50, 1'b1);
        chk(dither_blocked == 0, "R7", dither_blocked, 0);
        run_cmp(150, "R7", lg);

        // R8: unusable settings
        do_cfg(7, 7, 1'b0);
        chk(cfg_bad == 1, "R8", cfg_bad, 1);
        run_cmp(30, "R8", lg);
        do_cfg(0, 1, 1'b1);
        chk(cfg_bad == 1, "R8", cfg_bad, 1);
        run_cmp(30, "R8", lg);

        // R9: zero numerator with dither
        do_cfg(0, 100, 1'b1);
        chk(cfg_bad == 0, "R9", cfg_bad, 0);
        run_cmp(200, "R9", lg);

        // R10: restart reproduces the sequence
        lg.delete(); lg2.delete();
        do_cfg(37, 211, 1'b1); run_cmp(80, "R10", lg);
        do_cfg(37, 211, 1'b1); run_cmp(80, "R10", lg2);
        diff = 0;
        for (int i = 0; i < 80; i++) if (lg[i] != lg2[i]) diff++;
        chk(diff == 0, "R10", diff, 0);

        // R11: pausing the tick holds state and output
        lg.delete();
        do_cfg(13, 97, 1'b1);
        run_cmp(37, "R11", lg);
        hold_v = lg[36];
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(int'(offset_out) == hold_v, "R11", int'(offset_out), hold_v);
        end
        run_cmp(60, "R11", lg);

        // random settings, dither on and off
        for (int t = 0; t < 16; t++) begin
            int m, f;
            bit d;
            m = (t % 4 == 0) ? 2 + int'($urandom % 4094) : 2 + int'($urandom % 600);
            f = int'($urandom % m);
            d = $urandom % 2;
            do_cfg(f, m, d);
            run_cmp(400, "R2", lg);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule